// File: doc/BRIEF.md
# Two-bit pending/queued interrupt source

This block models one interrupt event source. Its delivery state is held in two bits: P (a notification has been sent and is not yet acknowledged) and Q (another event arrived while P was set). Software controls the source only through a small register window. Loads at certain offsets have side effects and return the state as it was before the access. Stores either acknowledge the source or inject an event, for example from a message-signalled interrupt or an interprocessor interrupt.

The source side is a single input. A parameter makes that input either an event pulse (edge source) or a held request line (level source). When an event meets an idle source, the block raises a one-cycle `notify` pulse toward the routing logic. While the state is 01 the source is masked. While the state is 10 a second event is recorded in Q and nothing is sent. An acknowledge that finds Q set sends the event again. A level source can also be acknowledged through a dedicated cycle, which sends again when the request line is still high. A build option reproduces a decoding fault in which the offset is ORed with itself shifted left by four bits before it is decoded.

Top module: `pq_src`

## Requirements
- R1: After reset the state is PQ=01 (masked), `notify` is low, and a state read returns 0x01.
- R2: A load with operation code 4 (effective offset bits [11:8]) returns the current state in rsp_data[1:0], with P in bit 1 and Q in bit 0 and all higher bits zero. The load leaves the state unchanged.
- R3: A load with operation code 0xC, 0xD, 0xE or 0xF returns the prior state and then sets the state to the low two bits of the code (00, 01, 10 or 11).
- R4: An event moves 00 to 10 and pulses `notify` in the cycle after the access, and moves 10 to 11. Events at 01 or 11 send nothing and change nothing.
- R5: A load with operation code 0 (acknowledge) returns the old Q in rsp_data[0] with zeros above it, and clears both bits. If the old Q was 1, the block then applies an event, so the state becomes 10 and `notify` pulses.
- R6: A store with operation code 0 has the same effect on the state as R5, and it produces no response.
- R7: A store with operation code 2 acts as an event on the source.
- R8: With LEVEL_SRC=1, an event is a rising edge of `src_in`. A load with operation code 1 returns the prior state and clears it to 00, then applies an event if `src_in` is still high. With LEVEL_SRC=0, an event is any cycle with `src_in` high, and a load with code 1 is invalid.
- R9: With ERRATA_SHIFT=1, the offset is decoded after being ORed with itself shifted left by 4 and truncated to the offset width. So offset 0x040 selects code 4, where it would select code 0 without the option.
- R10: A load with an undefined code returns all ones, meaning the state is invalid, and leaves the state unchanged. A store with any code other than 0 or 2 is ignored. Responses come one cycle after a load, and only after a load.
- R11: When a bus access and an event fall in the same cycle, the access is applied first and the event is applied to the result. The returned value is the state from before both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 for store, 0 for load |
| bus_offset | input | OFS_W | Access offset within the source window |
| rsp_valid | output | 1 | Load response valid, one cycle after the load |
| rsp_data | output | DATA_W | Load response data |
| src_in | input | 1 | Event pulse (edge) or request line (level) |
| notify | output | 1 | One-cycle notification pulse toward routing |

## Verification
The bench builds two instances side by side. The first uses the defaults: an edge source with normal decoding. It covers the Q-driven resend on acknowledge, the store paths, the masked state and undefined codes. The second sets LEVEL_SRC=1 and ERRATA_SHIFT=1, which makes the level acknowledge cycle and the shifted offset decode reachable. Because both instances share stimulus offsets, the same offset can be seen decoding differently in the two builds.

// File: rtl/pq_src_pkg.sv
package pq_src_pkg;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_ACK,
        OP_LVL_ACK,
        OP_READ,
        OP_FORCE,
        OP_EVENT,
        OP_BAD
    } pq_op_e;

    localparam logic [3:0] CODE_ACK     = 4'h0;
    localparam logic [3:0] CODE_LVL_ACK = 4'h1;
    localparam logic [3:0] CODE_EVENT   = 4'h2;
    localparam logic [3:0] CODE_READ    = 4'h4;

    localparam logic [1:0] PQ_IDLE = 2'b00;
    localparam logic [1:0] PQ_OFF  = 2'b01;
    localparam logic [1:0] PQ_SENT = 2'b10;
    localparam logic [1:0] PQ_QUED = 2'b11;

    // Returns {send, next_state} for an event applied to a state.
    function automatic logic [2:0] apply_event(input logic [1:0] cur);
        logic [2:0] r;
        case (cur)
            PQ_IDLE: r = {1'b1, PQ_SENT};
            PQ_SENT: r = {1'b0, PQ_QUED};
            default: r = {1'b0, cur};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pq_src_decode.sv
module pq_src_decode
    import pq_src_pkg::*;
#(
    parameter int OFS_W        = 12,
    parameter bit ERRATA_SHIFT = 1'b0,
    parameter bit LEVEL_SRC    = 1'b0
) (
    input  logic             acc_valid,
    input  logic             acc_write,
    input  logic [OFS_W-1:0] acc_offset,
    output pq_op_e           dec_op,
    output logic [1:0]       dec_force_val
);
    localparam int CODE_LSB = OFS_W - 4;

    logic [OFS_W-1:0] eff_ofs;
    logic [3:0]       code;

    generate
        if (ERRATA_SHIFT) begin : g_shift_fault
            assign eff_ofs = acc_offset | (acc_offset << 4);
        end else begin : g_plain
            assign eff_ofs = acc_offset;
        end
    endgenerate

    assign code          = eff_ofs[OFS_W-1:CODE_LSB];
    assign dec_force_val = code[1:0];

    always_comb begin
        dec_op = OP_NONE;
        if (acc_valid) begin
            if (acc_write) begin
                case (code)
                    CODE_ACK:   dec_op = OP_ACK;
                    CODE_EVENT: dec_op = OP_EVENT;
                    default:    dec_op = OP_NONE;
                endcase
            end else begin
                if (code == CODE_ACK)
                    dec_op = OP_ACK;
                else if (code == CODE_LVL_ACK)
                    dec_op = LEVEL_SRC ? OP_LVL_ACK : OP_BAD;
                else if (code == CODE_READ)
                    dec_op = OP_READ;
                else if (code[3:2] == 2'b11)
                    dec_op = OP_FORCE;
                else
                    dec_op = OP_BAD;
            end
        end
    end

endmodule

// File: rtl/pq_src_evt_in.sv
module pq_src_evt_in #(
    parameter bit LEVEL_SRC = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic evt
);
    generate
        if (LEVEL_SRC) begin : g_level
            logic prev_d, prev_q;

            always_comb begin
                prev_d = line_in;
            end

            always_ff @(posedge clk) begin
                if (!rst_n) prev_q <= 1'b0;
                else        prev_q <= prev_d;
            end

            assign evt = line_in & ~prev_q;
        end else begin : g_edge
            assign evt = line_in;
        end
    endgenerate

endmodule

// File: rtl/pq_src.sv
module pq_src
    import pq_src_pkg::*;
#(
    parameter int OFS_W        = 12,
    parameter int DATA_W       = 8,
    parameter bit LEVEL_SRC    = 1'b0,
    parameter bit ERRATA_SHIFT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [OFS_W-1:0]  bus_offset,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    input  logic              src_in,
    output logic              notify
);
    localparam int PAD_W = DATA_W - 2;

    typedef struct packed {
        logic [1:0]        pq;
        logic              ntf;
        logic              rv;
        logic [DATA_W-1:0] rd;
    } st_t;

    pq_op_e     op;
    logic [1:0] force_val;
    logic       evt_src;
    st_t        st_d, st_q;

    pq_src_decode #(
        .OFS_W       (OFS_W),
        .ERRATA_SHIFT(ERRATA_SHIFT),
        .LEVEL_SRC   (LEVEL_SRC)
    ) u_dec (
        .acc_valid    (bus_valid),
        .acc_write    (bus_write),
        .acc_offset   (bus_offset),
        .dec_op       (op),
        .dec_force_val(force_val)
    );

    pq_src_evt_in #(.LEVEL_SRC(LEVEL_SRC)) u_evt (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_in(src_in),
        .evt    (evt_src)
    );

    always_comb begin
        logic [1:0] mid;
        logic       ev;
        logic [2:0] res;
        mid = st_q.pq;
        ev  = evt_src;
        st_d.rv = 1'b0;
        st_d.rd = '0;
        case (op)
            OP_ACK: begin
                if (!bus_write) begin
                    st_d.rv = 1'b1;
                    st_d.rd = {{PAD_W{1'b0}}, 1'b0, st_q.pq[0]};
                end
                mid = PQ_IDLE;
                if (st_q.pq[0]) ev = 1'b1;
            end
            OP_LVL_ACK: begin
                st_d.rv = 1'b1;
                st_d.rd = {{PAD_W{1'b0}}, st_q.pq};
                mid = PQ_IDLE;
                if (src_in) ev = 1'b1;
            end
            OP_READ: begin
                st_d.rv = 1'b1;
                st_d.rd = {{PAD_W{1'b0}}, st_q.pq};
            end
            OP_FORCE: begin
                st_d.rv = 1'b1;
                st_d.rd = {{PAD_W{1'b0}}, st_q.pq};
                mid = force_val;
            end
            OP_EVENT: ev = 1'b1;
            OP_BAD: begin
                st_d.rv = 1'b1;
                st_d.rd = '1;
            end
            default: ;
        endcase
        res = apply_event(mid);
        if (ev) begin
            st_d.pq  = res[1:0];
            st_d.ntf = res[2];
        end else begin
            st_d.pq  = mid;
            st_d.ntf = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pq  <= PQ_OFF;
            st_q.ntf <= 1'b0;
            st_q.rv  <= 1'b0;
            st_q.rd  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid = st_q.rv;
    assign rsp_data  = st_q.rd;
    assign notify    = st_q.ntf;

    AST_RSP_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(bus_valid && !bus_write)); // R10
    AST_NOTIFY_SENT: assert property (@(posedge clk) disable iff (!rst_n)
        notify |-> st_q.pq == PQ_SENT); // R4
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pq == PQ_OFF && !bus_valid) |=> !notify); // R4
    AST_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_READ && !evt_src) |=> st_q.pq == $past(st_q.pq)); // R2
    AST_ACK_CLEARS_Q: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_ACK) |=> !st_q.pq[0]); // R5

endmodule

// File: tb/pq_src_test.sv
module pq_src_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic        a_v = 0, a_w = 0, a_s = 0, b_v = 0, b_w = 0, b_s = 0;
    logic [11:0] a_o = '0, b_o = '0;
    logic        a_rv, b_rv, a_nt, b_nt;
    logic [7:0]  a_rd, b_rd;

    pq_src #(.LEVEL_SRC(1'b0), .ERRATA_SHIFT(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .bus_valid(a_v), .bus_write(a_w),
        .bus_offset(a_o), .rsp_valid(a_rv), .rsp_data(a_rd),
        .src_in(a_s), .notify(a_nt));

    pq_src #(.LEVEL_SRC(1'b1), .ERRATA_SHIFT(1'b1)) uut_b (
        .clk(clk), .rst_n(rst_n), .bus_valid(b_v), .bus_write(b_w),
        .bus_offset(b_o), .rsp_valid(b_rv), .rsp_data(b_rd),
        .src_in(b_s), .notify(b_nt));

    int    n_cmp = 0, n_bad = 0;
    string tag = "R1";
    bit    done = 0;

    int m_pq[2], m_rd[2];
    bit m_prev[2], m_nt[2], m_rv[2];

    task automatic model(input int i, input bit lvl, input bit err,
                         input bit v, input bit w, input int ofs, input bit s);
        int eff, code, pq, nxt, rd;
        bit ev, rv;
        eff = err ? ((ofs | (ofs << 4)) & 12'hFFF) : ofs;
        code = eff >> 8;
        pq = m_pq[i]; nxt = pq; rv = 0; rd = 0;
        ev = lvl ? (s && !m_prev[i]) : s;
        if (v && !w) begin
            rv = 1;
            if (code == 0) begin rd = pq & 1; nxt = 0; if (pq & 1) ev = 1; end
            else if (code == 1 && lvl) begin rd = pq; nxt = 0; if (s) ev = 1; end
            else if (code == 4) rd = pq;
            else if (code >= 12) begin rd = pq; nxt = code & 3; end
            else rd = 255;
        end else if (v && w) begin
            if (code == 0) begin nxt = 0; if (pq & 1) ev = 1; end
            else if (code == 2) ev = 1;
        end
        m_nt[i] <= 0;
        if (ev) begin
            if (nxt == 0) begin nxt = 2; m_nt[i] <= 1; end
            else if (nxt == 2) nxt = 3;
        end
        m_pq[i] <= nxt; m_rv[i] <= rv; m_rd[i] <= rd; m_prev[i] <= s;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 2; i++) begin
                m_pq[i] <= 1; m_nt[i] <= 0; m_rv[i] <= 0; m_rd[i] <= 0; m_prev[i] <= 0;
            end
        end else begin
            model(0, 0, 0, a_v, a_w, int'(a_o), a_s);
            model(1, 1, 1, b_v, b_w, int'(b_o), b_s);
        end
    end

    task automatic cmp(input string who, input bit nt, input bit rv, input logic [7:0] rd,
                       input int i);
        n_cmp++;
        if (nt !== m_nt[i] || rv !== m_rv[i] || rd !== 8'(m_rd[i])) begin
            n_bad++;
            $display("FAIL %s %s: got notify=%0b rsp=%0b data=%02h, expected notify=%0b rsp=%0b data=%02h",
                     tag, who, nt, rv, rd, m_nt[i], m_rv[i], 8'(m_rd[i]));
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            cmp("edge", a_nt, a_rv, a_rd, 0);
            cmp("level", b_nt, b_rv, b_rd, 1);
        end
    end

    task automatic acc_a(input bit w, input logic [11:0] o);
        @(negedge clk); a_v = 1; a_w = w; a_o = o;
        @(negedge clk); a_v = 0; a_w = 0;
    endtask
    task automatic acc_b(input bit w, input logic [11:0] o);
        @(negedge clk); b_v = 1; b_w = w; b_o = o;
        @(negedge clk); b_v = 0; b_w = 0;
    endtask
    task automatic pulse_a;
        @(negedge clk); a_s = 1;
        @(negedge clk); a_s = 0;
    endtask

    task automatic run;
        repeat (3) @(negedge clk);
        rst_n = 1;
        tag = "R1"; acc_a(0, 12'h400); acc_b(0, 12'h040);
        tag = "R3"; acc_a(0, 12'hC00); acc_a(0, 12'hE00); acc_a(0, 12'hC00);
        tag = "R4"; pulse_a(); pulse_a(); pulse_a();
        tag = "R2"; acc_a(0, 12'h400);
        tag = "R5"; acc_a(0, 12'h000); acc_a(0, 12'h000); acc_a(0, 12'h400);
        tag = "R7"; acc_a(1, 12'h200); acc_a(0, 12'h400);
        tag = "R6"; acc_a(0, 12'hF00); acc_a(1, 12'h000); acc_a(1, 12'h000); acc_a(0, 12'h400);
        tag = "R4"; acc_a(0, 12'hD00); pulse_a(); acc_a(1, 12'h200); acc_a(0, 12'h400);
        tag = "R10"; acc_a(0, 12'h300); acc_a(0, 12'h200); acc_a(1, 12'h700);
        acc_a(0, 12'h100); acc_a(0, 12'h400);
        tag = "R11"; acc_a(0, 12'hC00);
        @(negedge clk); a_v = 1; a_w = 0; a_o = 12'hC00; a_s = 1;
        @(negedge clk); a_v = 0; a_s = 0;
        @(negedge clk); a_v = 1; a_w = 0; a_o = 12'h400; a_s = 1;
        @(negedge clk); a_v = 0; a_s = 0;
        acc_a(0, 12'h400);
        tag = "R9"; acc_b(0, 12'h0C0); acc_b(0, 12'h040); acc_a(0, 12'h040);
        tag = "R8";
        @(negedge clk); b_s = 1;
        repeat (3) @(negedge clk);
        acc_b(0, 12'h010); acc_b(0, 12'h040);
        @(negedge clk); b_s = 0;
        acc_b(0, 12'h010); acc_b(0, 12'h040);
        acc_b(1, 12'h020); acc_b(0, 12'h000); acc_b(0, 12'h000);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        fork
            run();
            begin
                repeat (20000) @(posedge clk);
                n_bad++;
                $display("FAIL watchdog: got no end, expected end of sequence");
            end
        join_any
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule